// File: doc/BRIEF.md
# Self-Gated Run Detector

This block watches a stream of symbols and counts how many times in a row a chosen key symbol has arrived. Once the run reaches a set length it raises a hit flag. The hit flag stays up for as long as the key keeps arriving. Cycles without a valid symbol leave the count where it is. A valid symbol that is not the key clears the count.

The count register is not clocked by the free-running clock. It is clocked by a local clock that an activation function switches off by itself. The activation function looks at the incoming symbol, the present count and the present flags. It keeps the local clock running only when the count or the flags are about to change, or when reset is applied.

The enable passes through a level-sensitive latch that is open while the global clock is low. A glitch on the enable therefore cannot reach the gated clock. The gated clock, the latched enable and a counter of suppressed edges are brought out, so that gating can be watched from outside.

Top module: `self_gated_detector`

## Requirements
- R1: On a global clock edge with `valid_i` high and `data_i` equal to the key (default 4'hA), `level_o` increments by one, saturating at RUN_LEN (default 3). With `valid_i` high and any other symbol, `level_o` becomes 0. With `valid_i` low, `level_o` holds.
- R2: `hit_o` is 1 exactly when `level_o` equals RUN_LEN. `busy_o` is 1 exactly when `level_o` is nonzero.
- R3: While the global clock is low, `gclk_en_o` equals 1 when reset is high or when the next count differs from the present one. Otherwise it equals 0.
- R4: `gclk_o` is low whenever the global clock is low. During the high phase it copies the enable that was latched before the rising edge, so a disabled cycle produces no pulse.
- R5: Reset is synchronous and active high. An edge with `rst` high sets `level_o` and `idle_cnt_o` to 0, and the gate stays enabled during reset.
- R6: Outside reset, `idle_cnt_o` advances by one (wrapping at its width) on every global edge whose latched enable is 0. It holds on every enabled edge.
- R7: The sequence of `level_o` values is identical, cycle by cycle, to that of an ungated machine given the same inputs.
- R8: When a key arrives while `hit_o` is high, `hit_o` stays high and that cycle is gated off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Symbol present this cycle |
| data_i | input | DATA_W | Incoming symbol |
| level_o | output | LVL_W | Current run length |
| hit_o | output | 1 | Run length reached RUN_LEN |
| busy_o | output | 1 | Run length nonzero |
| gclk_o | output | 1 | Gated clock driving the count register |
| gclk_en_o | output | 1 | Latched gate enable |
| idle_cnt_o | output | CNT_W | Count of suppressed clock edges |

## Verification
Two things can fall in the same cycle. Reset can coincide with a cycle in which the activation function would otherwise close the gate, such as a saturated hit receiving another key. A mismatch can also arrive in the very cycle the run would saturate. The bench drives both cases on purpose and mixes them into seeded random traffic. For every cycle it checks the latched enable in the low phase and the gated clock in the high phase. After each edge it compares the count, the flags and the suppressed-edge counter against an ungated reference model kept in the bench.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  typedef struct packed {
    logic hit;
    logic busy;
  } sgd_flags_t;
endpackage

// File: rtl/sgd_next.sv
module sgd_next
  import sgd_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter logic [DATA_W-1:0] KEY = 4'hA,
  parameter int RUN_LEN = 3,
  parameter int LVL_W = $clog2(RUN_LEN + 1)
) (
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LVL_W-1:0]  lvl_q,
  output logic [LVL_W-1:0]  lvl_d,
  output sgd_flags_t        flags_cur,
  output sgd_flags_t        flags_nxt
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(RUN_LEN);

  function automatic sgd_flags_t decode(input logic [LVL_W-1:0] l);
    sgd_flags_t f;
    f.hit  = (l == TOP);
    f.busy = (l != '0);
    return f;
  endfunction

  always_comb begin
    lvl_d = lvl_q;
    if (valid_i) begin
      if (data_i == KEY) lvl_d = (lvl_q == TOP) ? TOP : lvl_q + 1'b1;
      else               lvl_d = '0;
    end
    flags_cur = decode(lvl_q);
    flags_nxt = decode(lvl_d);
  end
endmodule

// File: rtl/sgd_activation.sv
module sgd_activation
  import sgd_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic             rst,
  input  logic [LVL_W-1:0] lvl_q,
  input  logic [LVL_W-1:0] lvl_d,
  input  sgd_flags_t       flags_cur,
  input  sgd_flags_t       flags_nxt,
  output logic             en
);
  logic stop;
  always_comb begin
    stop = !rst && (lvl_d == lvl_q) && (flags_nxt == flags_cur);
    en   = !stop;
  end
endmodule

// File: rtl/sgd_clk_gate.sv
module sgd_clk_gate (
  input  logic clk,
  input  logic en_i,
  output logic en_lat_o,
  output logic gclk_o
);
  always_latch begin
    if (!clk) en_lat_o = en_i;
  end
  assign gclk_o = clk & en_lat_o;
endmodule

// File: rtl/self_gated_detector.sv
module self_gated_detector
  import sgd_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter logic [DATA_W-1:0] KEY = 4'hA,
  parameter int RUN_LEN = 3,
  parameter int CNT_W = 16,
  localparam int LVL_W = $clog2(RUN_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [LVL_W-1:0]  level_o,
  output logic              hit_o,
  output logic              busy_o,
  output logic              gclk_o,
  output logic              gclk_en_o,
  output logic [CNT_W-1:0]  idle_cnt_o
);
  logic [LVL_W-1:0] lvl_q, lvl_d;
  sgd_flags_t       fl_cur, fl_nxt;
  logic             en_raw, en_lat, gclk;

  sgd_next #(.DATA_W(DATA_W), .KEY(KEY), .RUN_LEN(RUN_LEN), .LVL_W(LVL_W)) u_next (
    .valid_i(valid_i), .data_i(data_i), .lvl_q(lvl_q),
    .lvl_d(lvl_d), .flags_cur(fl_cur), .flags_nxt(fl_nxt)
  );

  sgd_activation #(.LVL_W(LVL_W)) u_act (
    .rst(rst), .lvl_q(lvl_q), .lvl_d(lvl_d),
    .flags_cur(fl_cur), .flags_nxt(fl_nxt), .en(en_raw)
  );

  sgd_clk_gate u_gate (.clk(clk), .en_i(en_raw), .en_lat_o(en_lat), .gclk_o(gclk));

  always_ff @(posedge gclk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl_d;
  end

  always_ff @(posedge clk) begin
    if (rst)          idle_cnt_o <= '0;
    else if (!en_lat) idle_cnt_o <= idle_cnt_o + 1'b1;
  end

  assign level_o   = lvl_q;
  assign hit_o     = fl_cur.hit;
  assign busy_o    = fl_cur.busy;
  assign gclk_o    = gclk;
  assign gclk_en_o = en_lat;

  // R1: without a valid symbol the count holds across the edge
  a_r1_hold_invalid: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(lvl_q));
  // R2: a hit always implies a nonzero run
  a_r2_hit_busy: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> busy_o);
  // R3: any pending change of the count must find the gate open
  a_r3_open_on_change: assert property (@(posedge clk) disable iff (rst)
    (lvl_d != lvl_q) |-> en_lat);
  // R5: reset clears the count through the gated clock
  a_r5_reset_clears: assert property (@(posedge clk)
    rst |=> (lvl_q == '0) && (idle_cnt_o == '0));
  // R6: an open gate leaves the suppressed-edge counter alone
  a_r6_cnt_holds_open: assert property (@(posedge clk) disable iff (rst)
    en_lat |=> $stable(idle_cnt_o));
  // R8: a key in the hit state keeps the hit
  a_r8_hit_sticks: assert property (@(posedge clk) disable iff (rst)
    (hit_o && valid_i && data_i == KEY) |=> hit_o);
endmodule

// File: tb/self_gated_detector_tb.sv
module self_gated_detector_tb;
  localparam int PERIOD = 10;
  localparam int DATA_W = 4;
  localparam logic [3:0] KEY = 4'hA;
  localparam int RUN_LEN = 3;
  localparam int CNT_W = 16;
  localparam int LVL_W = 2;

  logic clk = 1'b0, rst = 1'b1, valid_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic [LVL_W-1:0] level_o;
  logic hit_o, busy_o, gclk_o, gclk_en_o;
  logic [CNT_W-1:0] idle_cnt_o;

  int checks = 0, failures = 0;
  int ref_lvl = 0;
  int ref_idle = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  self_gated_detector #(.DATA_W(DATA_W), .KEY(KEY), .RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .data_i(data_i),
    .level_o(level_o), .hit_o(hit_o), .busy_o(busy_o), .gclk_o(gclk_o),
    .gclk_en_o(gclk_en_o), .idle_cnt_o(idle_cnt_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_next(input int l, input bit v, input logic [3:0] d, input bit r);
    if (r) return 0;
    if (!v) return l;
    if (d == KEY) return (l == RUN_LEN) ? RUN_LEN : l + 1;
    return 0;
  endfunction

  task automatic step(input bit r, input bit v, input logic [3:0] d);
    int nxt;
    bit exp_en;
    @(negedge clk);
    rst = r; valid_i = v; data_i = d;
    nxt = model_next(ref_lvl, v, d, r);
    exp_en = r || (nxt != ref_lvl);
    #1;
    chk("R3 enable", gclk_en_o, exp_en);
    chk("R4 gclk low phase", gclk_o, 0);
    @(posedge clk);
    #1;
    chk("R4 gclk high phase", gclk_o, exp_en);
    if (r) ref_idle = 0;
    else if (!exp_en) ref_idle = (ref_idle + 1) % (1 << CNT_W);
    ref_lvl = nxt;
    chk("R1/R7 level", level_o, ref_lvl);
    chk("R2 hit", hit_o, ref_lvl == RUN_LEN);
    chk("R2 busy", busy_o, ref_lvl != 0);
    chk("R6 idle count", idle_cnt_o, ref_idle);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R5 reset state
    step(1, 0, 0);
    step(1, 1, KEY);
    chk("R5 level after reset", level_o, 0);
    chk("R5 idle after reset", idle_cnt_o, 0);
    // R1 run up to saturation, then R8 sticky hit gated off
    step(0, 1, KEY); step(0, 1, KEY); step(0, 0, 4'h3); step(0, 1, KEY);
    chk("R2 hit reached", hit_o, 1);
    step(0, 1, KEY);
    chk("R8 hit held with gate closed", gclk_en_o, 0);
    chk("R8 hit stays", hit_o, 1);
    // R5 reset coinciding with a would-be idle cycle
    step(1, 1, KEY);
    chk("R5 reset over idle", level_o, 0);
    // mismatch on the saturating cycle
    step(0, 1, KEY); step(0, 1, KEY); step(0, 1, 4'h5);
    chk("R1 mismatch clears", level_o, 0);
    // idle stretch at zero: R6 counts suppressed edges
    for (int i = 0; i < 5; i++) step(0, 1, 4'h1);
    for (int i = 0; i < 4; i++) step(0, 0, KEY);
    // seeded random traffic against the ungated model (R7)
    for (int i = 0; i < 3000; i++) begin
      bit v;
      logic [3:0] d;
      v = ($urandom % 4) != 0;
      d = (($urandom % 2) == 0) ? KEY : 4'($urandom);
      step(($urandom % 200) == 0, v, d);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule